// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes a 24-bit configuration word from a host over three wires: a serial clock, a serial data line and a frame enable. While the enable is high, each rising edge of the serial clock moves one data bit into a shift register. When the enable goes low, the whole register is copied into a holding latch. The latch is the only state that the rest of the synthesizer sees. Shifting never touches the active configuration, so a partly received word has no effect.

The latched word is split into these fields:

- a 14-bit loop divide code;
- a premix modulus select;
- a two-bit reference-rate select;
- a production-test flag;
- a timer request;
- a two-bit output-mode select;
- three status bits.

The output-mode field steers the three general-purpose outputs. In the normal mode they show the status bits. In the three test modes each one shows its own group of internal test nodes. All three serial wires are resynchronised to the system clock. A small state machine with the states IDLE, SHIFT and COMMIT turns the end of a frame into a one-cycle latch strobe. Its transitions are: IDLE to SHIFT when enable is seen high; SHIFT to COMMIT when enable is seen low; COMMIT to SHIFT if enable is already high again, otherwise COMMIT to IDLE.

Word bit k (k = 1 is the first bit shifted) ends up in shift-register position 24-k.

Top module: `ctl_word_rx`

## Requirements
- R1: A data bit is taken only on a rising edge of the serial clock while enable is high. Serial clock edges while enable is low leave the shift register unchanged.
- R2: The latched outputs keep their value while a frame is being shifted. They take the new word only after enable falls: no more than 6 system clocks after the falling edge reaches the pins.
- R3: `div_code` holds word bits 1 to 14, with bit 1 as its most significant bit.
- R4: `premix_div10` equals word bit 15 (0 = divide by 1, 1 = divide by 10).
- R5: `ref_sel` = {bit 16, bit 17}. The values 00, 01, 10 and 11 select 10, 12.5, 25 and 100 kHz.
- R6: `prod_test` equals word bit 18 and `timer_req` equals word bit 19.
- R7: `out_mode` = {bit 20, bit 21}. When it is 00, `bit_out` = {bit 22, bit 23, bit 24}, so `bit_out[2]` is bit 22.
- R8: When `out_mode` is m = 1, 2 or 3, `bit_out` = `test_nodes[3m-1:3m-3]`.
- R9: When more than 24 bits are clocked in one frame, the last 24 bits form the word.
- R10: After reset the latched word is all zeros, so every field is 0 and `bit_out` is 000.
- R11: A frame with no serial clock edges re-latches the unchanged shift register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock from host |
| ser_data | input | 1 | Serial data, first bit is divide-code MSB |
| ser_en | input | 1 | Frame enable, high while shifting, falling edge commits |
| test_nodes | input | 9 | Three 3-bit groups of internal test nodes |
| div_code | output | 14 | Latched loop divide code |
| premix_div10 | output | 1 | Latched premix modulus select |
| ref_sel | output | 2 | Latched reference-rate select |
| prod_test | output | 1 | Latched production-test flag |
| timer_req | output | 1 | Latched timer request |
| out_mode | output | 2 | Latched output-mode select |
| bit_out | output | 3 | General-purpose outputs |

## Verification
The assertions assume that the serial wires change much more slowly than the system clock. They also assume that a serial clock rising edge never lands in the same synchronised cycle as an enable edge. The shift register and commit checks rely on this. The stimulus keeps each serial clock phase, and the gap around every enable change, at four system clocks. Data changes only while the serial clock is low. The serial clock is always low when enable moves.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
    localparam int WORD_W = 24;
    localparam int DIV_W  = 14;
    localparam int NBIT   = 3;
    localparam int NTEST  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        OM_STATUS = 2'b00,
        OM_TEST1  = 2'b01,
        OM_TEST2  = 2'b10,
        OM_TEST3  = 2'b11
    } out_mode_e;

    // Field order follows shift order: the first bit shifted lands in the MSB.
    typedef struct packed {
        logic [DIV_W-1:0] div_code;
        logic             premix10;
        logic [1:0]       ref_sel;
        logic             prod_test;
        logic             timer_req;
        out_mode_e        mode;
        logic [NBIT-1:0]  status;
    } ctl_word_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import cwr_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         en_s,
    input  logic         dat_s,
    output logic [W-1:0] shreg,
    output logic         commit
);
    rx_state_e state, state_nx;
    logic      sclk_q;
    logic      sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_s)  state_nx = ST_SHIFT;
            ST_SHIFT:  if (!en_s) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = en_s ? ST_SHIFT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = (state == ST_COMMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (en_s && sclk_rise) shreg <= {shreg[W-2:0], dat_s};
        end
    end

    // R1: a qualified edge moves the register up by one and appends the data bit
    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && sclk_rise) |=> (shreg[0] == $past(dat_s)) && (shreg[W-1:1] == $past(shreg[W-2:0])));

    // R1: no enable, no movement
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(shreg));

    // R2: the end of a frame always produces a commit strobe
    a_r2_commit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_s) |=> commit);

    // R2: the commit strobe lasts a single cycle
    a_r2_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/word_latch.sv
module word_latch
    import cwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] shreg,
    output ctl_word_t         word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= ctl_word_t'(shreg);
    end

    // R2: configuration is untouched between commits
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));

    // R11: a commit copies whatever the shift register held
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (word_q == $past(shreg)));
endmodule

// File: rtl/bit_mux.sv
module bit_mux
    import cwr_pkg::*;
(
    input  out_mode_e              mode,
    input  logic [NBIT-1:0]        status,
    input  logic [NBIT*NTEST-1:0]  test_nodes,
    output logic [NBIT-1:0]        bit_out
);
    logic [NBIT-1:0] grp [NTEST];

    for (genvar g = 0; g < NTEST; g++) begin : g_grp
        assign grp[g] = test_nodes[g*NBIT +: NBIT];
    end

    always_comb begin
        bit_out = status;
        unique case (mode)
            OM_STATUS: bit_out = status;
            OM_TEST1:  bit_out = grp[0];
            OM_TEST2:  bit_out = grp[1];
            OM_TEST3:  bit_out = grp[2];
            default:   bit_out = status;
        endcase
    end
endmodule

// File: rtl/ctl_word_rx.sv
module ctl_word_rx
    import cwr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    ser_en,
    input  logic [NBIT*NTEST-1:0]   test_nodes,
    output logic [DIV_W-1:0]        div_code,
    output logic                    premix_div10,
    output logic [1:0]              ref_sel,
    output logic                    prod_test,
    output logic                    timer_req,
    output logic [1:0]              out_mode,
    output logic [NBIT-1:0]         bit_out
);
    logic [2:0]        sync_q;
    logic [WORD_W-1:0] shreg;
    logic              commit;
    ctl_word_t         word_q;

    serial_sync #(.W(3), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk, ser_en, ser_data}),
        .dout (sync_q)
    );

    shift_ctrl #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(sync_q[2]),
        .en_s  (sync_q[1]),
        .dat_s (sync_q[0]),
        .shreg (shreg),
        .commit(commit)
    );

    word_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .shreg (shreg),
        .word_q(word_q)
    );

    bit_mux u_mux (
        .mode      (word_q.mode),
        .status    (word_q.status),
        .test_nodes(test_nodes),
        .bit_out   (bit_out)
    );

    assign div_code     = word_q.div_code;
    assign premix_div10 = word_q.premix10;
    assign ref_sel      = word_q.ref_sel;
    assign prod_test    = word_q.prod_test;
    assign timer_req    = word_q.timer_req;
    assign out_mode     = word_q.mode;

    // R2: an enable high seen at the pins holds the configuration three cycles later
    a_r2_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[1] && $past(sync_q[1])) |=> $stable({div_code, premix_div10, ref_sel, prod_test, timer_req, out_mode}));
endmodule

// File: tb/test_ctl_word_rx.sv
module test_ctl_word_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_en = 1'b0;
    logic [8:0] test_nodes = 9'b101_011_110;
    logic [13:0] div_code;
    logic        premix_div10;
    logic [1:0]  ref_sel;
    logic        prod_test;
    logic        timer_req;
    logic [1:0]  out_mode;
    logic [2:0]  bit_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_word_rx i_ctl_word_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .test_nodes(test_nodes), .div_code(div_code),
        .premix_div10(premix_div10), .ref_sel(ref_sel), .prod_test(prod_test),
        .timer_req(timer_req), .out_mode(out_mode), .bit_out(bit_out)
    );

    localparam logic [23:0] VEC [8] = '{
        24'h000000, 24'hFFFFFF, 24'h800001, 24'h3FFF08,
        24'h555550, 24'hAAAAAA, 24'h123467, 24'h00A5F5
    };

    // word bit k (first shifted = 1)
    function automatic logic wb(input logic [23:0] w, input int k);
        return w[24-k];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic en_up();
        @(negedge clk) ser_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic en_down();
        repeat (4) @(negedge clk);
        ser_en = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w);
        en_up();
        for (int k = 1; k <= 24; k++) send_bit(wb(w, k));
        en_down();
    endtask

    task automatic check_word(input logic [23:0] w);
        logic [13:0] ed;
        logic [1:0]  em;
        logic [2:0]  eb;
        for (int k = 1; k <= 14; k++) ed[14-k] = wb(w, k);
        em = {wb(w, 20), wb(w, 21)};
        eb = (em == 2'b00) ? {wb(w, 22), wb(w, 23), wb(w, 24)} : test_nodes[3*em-1 -: 3];
        check("R3 div_code", 32'(div_code), 32'(ed));
        check("R4 premix", 32'(premix_div10), 32'(wb(w, 15)));
        check("R5 ref_sel", 32'(ref_sel), 32'({wb(w, 16), wb(w, 17)}));
        check("R6 prod_test", 32'(prod_test), 32'(wb(w, 18)));
        check("R6 timer_req", 32'(timer_req), 32'(wb(w, 19)));
        check("R7 out_mode", 32'(out_mode), 32'(em));
        check(em == 2'b00 ? "R7 bit_out status" : "R8 bit_out test", 32'(bit_out), 32'(eb));
    endtask

    task automatic check_zero(input string req);
        check(req, 32'({div_code, premix_div10, ref_sel, prod_test, timer_req, out_mode}), 32'd0);
        check(req, 32'(bit_out), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R10 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_zero("R10 after reset");

        // R3-related field decode table walk
        for (int i = 0; i < 8; i++) begin
            send_word(VEC[i]);
            check_word(VEC[i]);
        end

        // R2: outputs hold during shifting, update after fall
        send_word(24'h3FFF08);
        en_up();
        for (int k = 1; k <= 24; k++) send_bit(wb(24'h123467, k));
        repeat (6) @(negedge clk);
        check_word(24'h3FFF08); // R2 still old word
        en_down();
        check_word(24'h123467); // R2 new word

        // R1: clocks with enable low are ignored; R11 empty frame re-latches
        for (int k = 1; k <= 24; k++) send_bit(1'b1);
        check_word(24'h123467);
        en_up();
        en_down();
        check_word(24'h123467); // R11

        // R9: 30 bits, last 24 win
        en_up();
        for (int k = 0; k < 6; k++) send_bit(1'b1);
        for (int k = 1; k <= 24; k++) send_bit(wb(24'h00A5F5, k));
        en_down();
        check_word(24'h00A5F5);

        // R10: reset mid-operation clears the word
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_zero("R10 re-reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule